// File: doc/BRIEF.md
# Multi-Mode Timer and Event Counter

This block is a 16-bit up-counter with a reload register and three counting modes. It can count rising edges of an external pin, or ticks of an instruction-clock enable, or it can measure how long the pin stays at a chosen level. When the count passes its all-ones value it reloads from the reload register. At that point it sets a sticky interrupt flag, if interrupts are enabled, and it always raises a one-cycle wake strobe. The interrupt controller, CPU, prescaler and pin synchronizer sit outside. The pin arrives already synchronized, and the instruction tick arrives as a one-cycle enable.

Software drives the block through an 8-bit register bus with three locations: a low data port, a high data port and a control register. The 16-bit reload value is built in two steps. A low-byte write goes into a holding buffer, and the high-byte write then commits both bytes together. Reads work the other way round: reading the high byte takes a snapshot of the live low byte, so a 16-bit value read as high then low is coherent. In pulse-width mode the block waits for the selected edge, counts while the level persists, and clears its own run bit when the level ends. The measured value stays in the counter.

Top module: `multimode_timer`

## Requirements
- R1: A write to address 0 (low port) loads only the low-byte buffer. Neither the reload register nor the counter changes.
- R2: A write to address 1 (high port) sets the reload register to {written byte, low-byte buffer} at that clock edge.
- R3: Reads are combinational. Address 0 returns the low-byte buffer, not the live count. Address 1 returns counter[15:8] and copies counter[7:0] into the buffer at the edge. Address 2 returns the control register as {3'b0, run, edge_sel, 1'b0, mode[1:0]}.
- R4: Control bits [1:0] select the mode: 00 off, 01 event, 10 timer, 11 pulse-width. In event mode the counter adds one for each low-to-high transition of the pin and ignores the tick input.
- R5: In timer mode the counter adds one in each cycle where the tick input is 1.
- R6: Counting happens only while control bit 4 (run) is 1. With run at 0, or with mode 00, the counter holds its value.
- R7: An increment from FFFFh loads the reload value instead of 0000h. The wake output is 1 for exactly the next cycle.
- R8: In pulse-width mode with control bit 3 (edge_sel) at 1, the rising pin edge arms the measurement but does not count. Each later tick counts while the pin stays high. The first cycle with the pin low clears run and keeps the count, and further pin activity is then ignored.
- R9: In pulse-width mode with edge_sel at 0, the polarity is reversed: a falling edge arms the measurement, ticks count while the pin is low, and the return high ends it.
- R10: A high-port write while run is 0 also loads the counter with the new reload value. While run is 1 it changes only the reload register, and that value takes effect at the next overflow.
- R11: The interrupt flag is set by an overflow only while irq_enable is 1. Once set, it stays set until irq_clear is 1, and a new overflow in the same cycle wins over the clear.
- R12: A counting event that falls in the same cycle as a high-port read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select: 0 low port, 1 high port, 2 control |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (has side effects at address 1) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on bus_addr |
| pin_sync | input | 1 | Synchronized external pin level |
| tick_en | input | 1 | Instruction-clock tick enable |
| irq_enable | input | 1 | Allows overflow to set the interrupt flag |
| irq_clear | input | 1 | Clears the interrupt flag |
| irq_flag | output | 1 | Sticky overflow interrupt request |
| wake | output | 1 | One-cycle strobe after each overflow |

## Verification
Register writes and counter changes show up one clock edge after the strobe. Read data is valid within the strobed cycle, and the low-byte snapshot from a high-port read is available from the next cycle on. The wake strobe and the interrupt flag both appear in the cycle after the edge that wraps the counter. The pulse-width run bit clears on the edge where the pin first shows the inactive level, and the arming edge itself adds no count. The bench drives every input at a falling clock edge and samples half a cycle later. It counts wake pulses with a falling-edge monitor and reads the count only after stopping the counter, so the cycle-exact counts above (for example 5 for a six-cycle high pulse, or one lost tick for a read in the middle of a run) are compared directly.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } mode_e;

  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  localparam int RUN_BIT  = 4;
  localparam int EDGE_BIT = 3;
endpackage

// File: rtl/mmt_regs.sv
module mmt_regs
  import mmt_pkg::*;
#(
  parameter int DW = 8,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] cnt,
  input  logic          pw_done,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] reload,
  output logic [CW-1:0] reload_new,
  output logic          reload_wr,
  output logic [DW-1:0] lowbuf,
  output logic          run,
  output logic          edge_sel,
  output mode_e         mode,
  output logic          hi_rd
);
  logic lo_wr, ctrl_wr;

  assign lo_wr      = wr && (addr == ADDR_LO);
  assign reload_wr  = wr && (addr == ADDR_HI);
  assign ctrl_wr    = wr && (addr == ADDR_CTRL);
  assign hi_rd      = rd && (addr == ADDR_HI);
  assign reload_new = {wdata, lowbuf};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lowbuf   <= '0;
      reload   <= '0;
      run      <= 1'b0;
      edge_sel <= 1'b0;
      mode     <= MODE_OFF;
    end else begin
      if (lo_wr)      lowbuf <= wdata;
      else if (hi_rd) lowbuf <= cnt[DW-1:0];
      if (reload_wr)  reload <= reload_new;
      if (ctrl_wr) begin
        mode     <= mode_e'(wdata[1:0]);
        edge_sel <= wdata[EDGE_BIT];
        run      <= wdata[RUN_BIT];
      end else if (pw_done) begin
        run <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_LO:   rdata = lowbuf;
      ADDR_HI:   rdata = cnt[CW-1:DW];
      ADDR_CTRL: begin
        rdata[1:0]      = mode;
        rdata[EDGE_BIT] = edge_sel;
        rdata[RUN_BIT]  = run;
      end
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/mmt_ctl.sv
module mmt_ctl
  import mmt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e mode,
  input  logic  run,
  input  logic  edge_sel,
  input  logic  pin,
  input  logic  tick,
  input  logic  hold,
  output logic  inc,
  output logic  pw_done,
  output logic  measuring
);
  logic pin_q, rise, fall, pin_act, arm_hit, raw;

  function automatic logic pick_edge(input logic r, input logic f, input logic sel);
    return sel ? r : f;
  endfunction

  assign rise    = pin && !pin_q;
  assign fall    = !pin && pin_q;
  assign pin_act = edge_sel ? pin : !pin;
  assign arm_hit = pick_edge(rise, fall, edge_sel);
  assign pw_done = run && (mode == MODE_PULSE) && measuring && !pin_act;

  always_comb begin
    unique case (mode)
      MODE_EVENT: raw = rise;
      MODE_TIMER: raw = tick;
      MODE_PULSE: raw = measuring && pin_act && tick;
      default:    raw = 1'b0;
    endcase
  end

  assign inc = run && raw && !hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q     <= 1'b0;
      measuring <= 1'b0;
    end else begin
      pin_q <= pin;
      if (!run || mode != MODE_PULSE) measuring <= 1'b0;
      else if (!measuring && arm_hit) measuring <= 1'b1;
      else if (pw_done)               measuring <= 1'b0;
    end
  end
endmodule

// File: rtl/mmt_counter.sv
module mmt_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] reload,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  logic [CW-1:0] nxt;
  logic          carry;

  function automatic logic [CW:0] step(input logic [CW-1:0] v);
    return {1'b0, v} + {{CW{1'b0}}, 1'b1};
  endfunction

  assign {carry, nxt} = step(cnt);
  assign wrap = inc && carry;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (wrap)  cnt <= reload;
    else if (inc)   cnt <= nxt;
  end
endmodule

// File: rtl/multimode_timer.sv
module multimode_timer
  import mmt_pkg::*;
#(
  parameter int DW = 8,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          pin_sync,
  input  logic          tick_en,
  input  logic          irq_enable,
  input  logic          irq_clear,
  output logic          irq_flag,
  output logic          wake
);
  logic [CW-1:0] cnt, reload, reload_new;
  logic [DW-1:0] lowbuf;
  logic          reload_wr, run, edge_sel, hi_rd;
  logic          inc, pw_done, measuring, wrap, load;
  mode_e         mode;

  assign load = reload_wr && !run;

  mmt_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .cnt(cnt), .pw_done(pw_done), .rdata(bus_rdata),
    .reload(reload), .reload_new(reload_new), .reload_wr(reload_wr),
    .lowbuf(lowbuf), .run(run), .edge_sel(edge_sel), .mode(mode), .hi_rd(hi_rd)
  );

  mmt_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .run(run), .edge_sel(edge_sel),
    .pin(pin_sync), .tick(tick_en), .hold(hi_rd), .inc(inc),
    .pw_done(pw_done), .measuring(measuring)
  );

  mmt_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(inc), .load(load), .load_val(reload_new),
    .reload(reload), .cnt(cnt), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_flag <= 1'b0;
      wake     <= 1'b0;
    end else begin
      wake <= wrap;
      if (wrap && irq_enable) irq_flag <= 1'b1;
      else if (irq_clear)     irq_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/mmt_checker.sv
module mmt_checker
  import mmt_pkg::*;
#(
  parameter int DW = 8,
  localparam int CW = 2 * DW
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] lowbuf,
  input logic [CW-1:0] reload,
  input logic [CW-1:0] cnt,
  input logic          run,
  input logic          load,
  input logic          wrap,
  input logic          pw_done,
  input logic          wake,
  input logic          irq_enable,
  input logic          irq_flag
);
  AST_LOW_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_LO) |=> $stable(reload)); // R1
  AST_HIGH_WRITE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_HI) |=> reload == {$past(bus_wdata), $past(lowbuf)}); // R2
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt)); // R6
  AST_WRAP_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == $past(reload)) && wake); // R7
  AST_PULSE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_done && !(bus_wr && bus_addr == ADDR_CTRL)) |=> !run); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_enable && !irq_flag) |=> !irq_flag); // R11
  AST_READ_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_HI && !load) |=> $stable(cnt)); // R12
endmodule

bind multimode_timer mmt_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .lowbuf(lowbuf), .reload(reload), .cnt(cnt), .run(run),
  .load(load), .wrap(wrap), .pw_done(pw_done), .wake(wake),
  .irq_enable(irq_enable), .irq_flag(irq_flag)
);

// File: tb/multimode_timer_test.sv
module multimode_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       pin_sync = 1'b0, tick_en = 1'b0;
  logic       irq_enable = 1'b1, irq_clear = 1'b0;
  logic       irq_flag, wake;

  int checks = 0, fails = 0, wake_seen = 0;
  bit done = 1'b0;

  // {preload, tick pulses, expected count, expected wake pulses}
  localparam logic [47:0] VEC [6] = '{
    {16'h0010, 8'd5, 16'h0015, 8'd0},
    {16'hFFFE, 8'd3, 16'hFFFF, 8'd1},
    {16'hFFFF, 8'd1, 16'hFFFF, 8'd1},
    {16'h00FF, 8'd1, 16'h0100, 8'd0},
    {16'h1234, 8'd0, 16'h1234, 8'd0},
    {16'hFFFD, 8'd4, 16'hFFFE, 8'd1}
  };

  always #2.5 clk = ~clk;

  multimode_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_sync(pin_sync),
    .tick_en(tick_en), .irq_enable(irq_enable), .irq_clear(irq_clear),
    .irq_flag(irq_flag), .wake(wake)
  );

  always @(negedge clk) if (rst_n && wake) wake_seen++;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic read16(output logic [15:0] v);
    logic [7:0] h, l;
    rd(2'd1, h);
    rd(2'd0, l);
    v = {h, l};
  endtask

  task automatic preload(input logic [7:0] ctrl, input logic [15:0] v);
    wr(2'd2, ctrl);
    wr(2'd0, v[7:0]);
    wr(2'd1, v[15:8]);
  endtask

  task automatic tick_pulse();
    tick_en = 1'b1; @(negedge clk);
    tick_en = 1'b0; @(negedge clk);
  endtask

  task automatic clear_irq();
    irq_clear = 1'b1; @(negedge clk);
    irq_clear = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R3 readback, R6 stopped, R11 flag)
    rd(2'd2, b); check("R3 reset ctrl", {8'h0, b}, 16'h0000);
    read16(v);   check("R6 reset count", v, 16'h0000);
    check("R11 reset irq", {15'h0, irq_flag}, 16'h0000);
    check("R7 reset wake", {15'h0, wake}, 16'h0000);

    // table walk: timer mode (R5, R7, R10 stopped load)
    foreach (VEC[i]) begin
      preload(8'h02, VEC[i][47:32]);
      wake_seen = 0;
      wr(2'd2, 8'h12);
      for (int k = 0; k < int'(VEC[i][31:24]); k++) tick_pulse();
      wr(2'd2, 8'h02);
      read16(v);
      check("R5 timer count", v, VEC[i][23:8]);
      check("R7 wake pulses", 16'(wake_seen), {8'h0, VEC[i][7:0]});
      check("R7 irq flag", {15'h0, irq_flag}, {15'h0, VEC[i][7:0] != 0});
      clear_irq();
    end

    // R1 / R3 / R2: buffer behaviour
    preload(8'h02, 16'hABCD);
    wr(2'd0, 8'h11);
    rd(2'd0, b); check("R3 low read gives buffer", {8'h0, b}, 16'h0011);
    rd(2'd1, b); check("R3 high read", {8'h0, b}, 16'h00AB);
    rd(2'd0, b); check("R1 counter kept after low write", {8'h0, b}, 16'h00CD);
    wr(2'd1, 8'h22);
    read16(v); check("R2 high write pairs latched low byte", v, 16'h22CD);

    // R3 control readback
    wr(2'd2, 8'h1A);
    rd(2'd2, b); check("R3 ctrl readback", {8'h0, b}, 16'h001A);
    wr(2'd2, 8'h02);

    // R6: stopped and mode off hold the count
    preload(8'h02, 16'h0040);
    tick_en = 1'b1; repeat (8) @(negedge clk); tick_en = 1'b0;
    read16(v); check("R6 stopped holds", v, 16'h0040);
    wr(2'd2, 8'h10);
    tick_en = 1'b1; repeat (8) @(negedge clk); tick_en = 1'b0;
    wr(2'd2, 8'h00);
    read16(v); check("R6 mode off holds", v, 16'h0040);

    // R4: event mode, ticks ignored
    preload(8'h01, 16'h0000);
    tick_en = 1'b1;
    wr(2'd2, 8'h11);
    for (int k = 0; k < 3; k++) begin
      pin_sync = 1'b1; repeat (2) @(negedge clk);
      pin_sync = 1'b0; repeat (2) @(negedge clk);
    end
    wr(2'd2, 8'h01);
    tick_en = 1'b0;
    read16(v); check("R4 event edges", v, 16'h0003);

    // R12: a high read drops a count
    preload(8'h02, 16'h0000);
    tick_en = 1'b1;
    wr(2'd2, 8'h12); repeat (4) @(negedge clk); wr(2'd2, 8'h02);
    tick_en = 1'b0;
    read16(v); check("R12 baseline five ticks", v, 16'h0005);
    preload(8'h02, 16'h0000);
    tick_en = 1'b1;
    wr(2'd2, 8'h12); repeat (2) @(negedge clk); rd(2'd1, b); @(negedge clk); wr(2'd2, 8'h02);
    tick_en = 1'b0;
    read16(v); check("R12 read drops one tick", v, 16'h0004);

    // R8: pulse width, active high
    preload(8'h0B, 16'h0000);
    tick_en = 1'b1;
    wr(2'd2, 8'h1B);
    repeat (3) @(negedge clk);
    pin_sync = 1'b1; repeat (6) @(negedge clk);
    pin_sync = 1'b0; repeat (2) @(negedge clk);
    pin_sync = 1'b1; repeat (3) @(negedge clk);
    pin_sync = 1'b0; repeat (2) @(negedge clk);
    tick_en = 1'b0;
    read16(v); check("R8 high pulse width", v, 16'h0005);
    rd(2'd2, b); check("R8 run self-cleared", {8'h0, b}, 16'h000B);

    // R9: pulse width, active low
    preload(8'h03, 16'h0000);
    pin_sync = 1'b1; repeat (2) @(negedge clk);
    tick_en = 1'b1;
    wr(2'd2, 8'h13);
    repeat (2) @(negedge clk);
    pin_sync = 1'b0; repeat (4) @(negedge clk);
    pin_sync = 1'b1; repeat (2) @(negedge clk);
    pin_sync = 1'b0; repeat (2) @(negedge clk);
    pin_sync = 1'b1; repeat (2) @(negedge clk);
    tick_en = 1'b0;
    read16(v); check("R9 low pulse width", v, 16'h0003);
    rd(2'd2, b); check("R9 run self-cleared", {8'h0, b}, 16'h0003);
    pin_sync = 1'b0; @(negedge clk);

    // R10: reload write while running
    preload(8'h02, 16'hFFF0);
    wr(2'd2, 8'h12);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h80);
    read16(v); check("R10 running write leaves counter", v, 16'hFFF0);
    wake_seen = 0;
    for (int k = 0; k < 16; k++) tick_pulse();
    wr(2'd2, 8'h02);
    read16(v); check("R10 new reload used at overflow", v, 16'h8000);
    check("R7 single wake", 16'(wake_seen), 16'h0001);
    check("R11 flag set", {15'h0, irq_flag}, 16'h0001);
    repeat (3) @(negedge clk);
    check("R11 flag sticky", {15'h0, irq_flag}, 16'h0001);
    clear_irq();
    check("R11 flag cleared", {15'h0, irq_flag}, 16'h0000);

    // R11: masked overflow still wakes
    irq_enable = 1'b0;
    preload(8'h02, 16'hFFFF);
    wake_seen = 0;
    wr(2'd2, 8'h12); tick_pulse(); wr(2'd2, 8'h02);
    check("R7 masked overflow wakes", 16'(wake_seen), 16'h0001);
    check("R11 masked no flag", {15'h0, irq_flag}, 16'h0000);
    irq_enable = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule